// File: doc/BRIEF.md
# Two-Hot Opcode Decoder Pipeline

This block takes an 8-bit operation field from instruction fetch and carries it down a three-stage pipeline: decode, execute and writeback. The field uses a sparse two-of-eight code. Each legal operation owns one pair of set bits, which gives 28 operations. There is no central decode table. Every stage makes its own one-hot operation lines from its local copy of the raw field. Each line is one AND gate across a bit pair, qualified by the stage's valid bit.

The number of set bits splits the codes into three classes:
- Zero or one set bit: the code is a NOP and enables nothing.
- Exactly two set bits: the code is a legal operation.
- Three or more set bits: the code is illegal. The decode stage finds this, the flag travels with the instruction, and it is reported at writeback. No operation line ever fires for an illegal code.

A stall input freezes the pipeline. A flush input empties it.

Top module: `twohot_opc_pipe`

## Requirements
- R1: A valid code with exactly two set bits at positions lo<hi drives exactly one operation line. Its index k counts the pairs in order of ascending lo, then ascending hi, so (0,1)->0, (0,2)->1, ..., (0,7)->6, (1,2)->7, ..., (6,7)->27. All 28 lines are reachable.
- R2: A valid code with zero or one set bit drives no operation line at any stage. It raises `wb_nop_o` for one cycle when it reaches writeback.
- R3: A valid code with three or more set bits drives no operation line at any stage. It raises `wb_illegal_o` for one cycle when it reaches writeback.
- R4: An instruction captured at clock edge k (stall low) shows on `dec_ops_o` after edge k, on `ex_ops_o` after edge k+1, and on the writeback outputs after edge k+2.
- R5: A cycle with `instr_valid_i` low enters the pipeline as a bubble. A bubble drives no operation line and no flag at any stage.
- R6: While `stall_i` is high, all stage registers hold their contents and nothing is captured. `dec_ops_o` and `ex_ops_o` hold. All writeback outputs are low, so each instruction retires exactly once.
- R7: `flush_i` clears every stage's valid bit at the next edge and takes priority over `stall_i`. The input instruction of that cycle is dropped.
- R8: At most one of `wb_nop_o`, `wb_illegal_o` and "any `wb_ops_o` line" is high in any cycle.
- R9: While `rst_ni` is low, and right after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze all stages |
| flush_i | input | 1 | Invalidate all stages |
| instr_valid_i | input | 1 | Opcode input carries an instruction |
| opcode_i | input | 8 | Raw two-hot operation field |
| dec_ops_o | output | 28 | One-hot operation lines, decode stage |
| ex_ops_o | output | 28 | One-hot operation lines, execute stage |
| wb_ops_o | output | 28 | One-hot operation lines, writeback stage |
| wb_nop_o | output | 1 | Writeback retires a NOP code |
| wb_illegal_o | output | 1 | Writeback retires an illegal code |

## Verification
The assertions check the following properties on every cycle:
- each stage's lines are at most one-hot;
- the writeback classes are mutually exclusive;
- writeback is silent during stall;
- decode and execute outputs hold under stall;
- the pipeline is empty after a flush;
- execute follows decode by one edge.

Some behaviour needs the bench's scenarios instead. Only a full sweep of all 256 codes can show that the pair-to-index mapping is correct, that all 28 lines are reached, and that the split is exactly 28 legal, 9 NOP and 219 illegal. The same holds for end-to-end latency under random stalls and flushes, which the bench checks against its own pipeline model.

// File: rtl/twohot_pkg.sv
package twohot_pkg;
  localparam int unsigned OPC_W_DEF = 8;
  localparam int unsigned NSTG      = 3;  // decode, execute, writeback

  // lexicographic pair index, lo ascending then hi ascending
  function automatic int pair_index(input int lo, input int hi, input int w);
    int k;
    k = 0;
    for (int l = 0; l < lo; l++) k += w - 1 - l;
    return k + (hi - lo - 1);
  endfunction
endpackage

// File: rtl/twohot_stage_reg.sv
module twohot_stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else if (clr_i) begin
      vld_o <= 1'b0;
    end else if (en_i) begin
      vld_o <= vld_i;
      q_o   <= d_i;
    end
  end
endmodule

// File: rtl/twohot_classify.sv
module twohot_classify #(
  parameter int unsigned OPC_W = 8
) (
  input  logic [OPC_W-1:0] opc_i,
  output logic             nop_o,
  output logic             ill_o
);
  localparam int unsigned CNT_W = $clog2(OPC_W + 1);
  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < OPC_W; i++) ones = ones + CNT_W'(opc_i[i]);
  end

  assign nop_o = (ones < CNT_W'(2));
  assign ill_o = (ones > CNT_W'(2));
endmodule

// File: rtl/twohot_op_decode.sv
module twohot_op_decode
  import twohot_pkg::*;
#(
  parameter int unsigned OPC_W = 8,
  localparam int unsigned NOPS = OPC_W * (OPC_W - 1) / 2
) (
  input  logic [OPC_W-1:0] opc_i,
  input  logic             qual_i,
  output logic [NOPS-1:0]  ops_o
);
  for (genvar lo = 0; lo < OPC_W - 1; lo++) begin : g_lo
    for (genvar hi = lo + 1; hi < OPC_W; hi++) begin : g_hi
      localparam int K = pair_index(lo, hi, OPC_W);
      assign ops_o[K] = qual_i & opc_i[lo] & opc_i[hi];
    end
  end
endmodule

// File: rtl/twohot_opc_pipe.sv
module twohot_opc_pipe
  import twohot_pkg::*;
#(
  parameter int unsigned OPC_W = OPC_W_DEF,
  localparam int unsigned NOPS = OPC_W * (OPC_W - 1) / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic             flush_i,
  input  logic             instr_valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic [NOPS-1:0]  dec_ops_o,
  output logic [NOPS-1:0]  ex_ops_o,
  output logic [NOPS-1:0]  wb_ops_o,
  output logic             wb_nop_o,
  output logic             wb_illegal_o
);
  localparam int unsigned LAST = NSTG - 1;

  logic [NSTG-1:0][OPC_W-1:0] opc_s;
  logic [NSTG-1:0][NOPS-1:0]  ops_s;
  logic [NSTG-1:0]            vld_s, nop_s, ill_s;

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    if (g == 0) begin : g_dec
      twohot_stage_reg #(.W(OPC_W)) u_reg (
        .clk_i, .rst_ni,
        .en_i (~stall_i), .clr_i(flush_i),
        .vld_i(instr_valid_i), .d_i(opcode_i),
        .vld_o(vld_s[g]), .q_o(opc_s[g])
      );
      // class is resolved once here and carried downstream
      twohot_classify #(.OPC_W(OPC_W)) u_cls (
        .opc_i(opc_s[g]), .nop_o(nop_s[g]), .ill_o(ill_s[g])
      );
    end else begin : g_carry
      logic [OPC_W+1:0] q;
      twohot_stage_reg #(.W(OPC_W + 2)) u_reg (
        .clk_i, .rst_ni,
        .en_i (~stall_i), .clr_i(flush_i),
        .vld_i(vld_s[g-1]), .d_i({ill_s[g-1], nop_s[g-1], opc_s[g-1]}),
        .vld_o(vld_s[g]), .q_o(q)
      );
      assign opc_s[g] = q[OPC_W-1:0];
      assign nop_s[g] = q[OPC_W];
      assign ill_s[g] = q[OPC_W+1];
    end

    twohot_op_decode #(.OPC_W(OPC_W)) u_dec (
      .opc_i (opc_s[g]),
      .qual_i(vld_s[g] & ~ill_s[g]),
      .ops_o (ops_s[g])
    );
  end

  logic retire;
  assign retire = vld_s[LAST] & ~stall_i;

  assign dec_ops_o    = ops_s[0];
  assign ex_ops_o     = ops_s[1];
  assign wb_ops_o     = retire ? ops_s[LAST] : '0;
  assign wb_nop_o     = retire & nop_s[LAST];
  assign wb_illegal_o = retire & ill_s[LAST];
endmodule

// File: rtl/twohot_opc_pipe_chk.sv
module twohot_opc_pipe_chk #(
  parameter int unsigned OPC_W = 8,
  localparam int unsigned NOPS = OPC_W * (OPC_W - 1) / 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stall_i,
  input logic             flush_i,
  input logic             instr_valid_i,
  input logic [OPC_W-1:0] opcode_i,
  input logic [NOPS-1:0]  dec_ops_o,
  input logic [NOPS-1:0]  ex_ops_o,
  input logic [NOPS-1:0]  wb_ops_o,
  input logic             wb_nop_o,
  input logic             wb_illegal_o
);
  p_onehot_ops_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dec_ops_o) && $onehot0(ex_ops_o) && $onehot0(wb_ops_o));

  p_illegal_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_illegal_o |-> (wb_ops_o == '0));

  p_ex_follows_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !flush_i) |=> (ex_ops_o == $past(dec_ops_o)));

  p_bubble_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!instr_valid_i && !stall_i && !flush_i) |=> (dec_ops_o == '0));

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush_i) |=> ($stable(dec_ops_o) && $stable(ex_ops_o)));

  p_stall_no_retire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (!wb_nop_o && !wb_illegal_o && wb_ops_o == '0));

  p_flush_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (dec_ops_o == '0 && ex_ops_o == '0 && wb_ops_o == '0
                 && !wb_nop_o && !wb_illegal_o));

  p_class_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({wb_nop_o, wb_illegal_o, |wb_ops_o}) <= 1);

  logic unused;
  assign unused = ^opcode_i;
endmodule

bind twohot_opc_pipe twohot_opc_pipe_chk #(.OPC_W(OPC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_i), .flush_i(flush_i),
  .instr_valid_i(instr_valid_i), .opcode_i(opcode_i),
  .dec_ops_o(dec_ops_o), .ex_ops_o(ex_ops_o), .wb_ops_o(wb_ops_o),
  .wb_nop_o(wb_nop_o), .wb_illegal_o(wb_illegal_o)
);

// File: tb/twohot_opc_pipe_tb.sv
`timescale 1ns/1ps
module twohot_opc_pipe_tb;
  localparam int OW = 8;
  localparam int NO = OW * (OW - 1) / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0, flush = 1'b0, ivld = 1'b0;
  logic [OW-1:0] opc = '0;
  logic [NO-1:0] dec_ops, ex_ops, wb_ops;
  logic          wb_nop, wb_ill;

  always #10 clk = ~clk;  // 50 MHz

  twohot_opc_pipe #(.OPC_W(OW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .flush_i(flush),
    .instr_valid_i(ivld), .opcode_i(opc),
    .dec_ops_o(dec_ops), .ex_ops_o(ex_ops), .wb_ops_o(wb_ops),
    .wb_nop_o(wb_nop), .wb_illegal_o(wb_ill)
  );

  int n_chk = 0, n_fail = 0;
  logic          m_vld [3];
  logic [OW-1:0] m_opc [3];
  int tally_op, tally_nop, tally_ill;
  logic [NO-1:0] seen;
  bit counting = 1'b0;

  function automatic logic [NO-1:0] exp_ops(logic [OW-1:0] o);
    logic [NO-1:0] r;
    int k;
    r = '0;
    k = 0;
    if ($countones(o) != 2) return '0;
    for (int lo = 0; lo < OW; lo++)
      for (int hi = lo + 1; hi < OW; hi++) begin
        if (o[lo] && o[hi]) r[k] = 1'b1;
        k++;
      end
    return r;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    logic ret;
    ret = m_vld[2] && !stall;
    chk(tag, "dec_ops", dec_ops, m_vld[0] ? exp_ops(m_opc[0]) : '0);
    chk(tag, "ex_ops",  ex_ops,  m_vld[1] ? exp_ops(m_opc[1]) : '0);
    chk(tag, "wb_ops",  wb_ops,  ret ? exp_ops(m_opc[2]) : '0);
    chk(tag, "wb_nop",  wb_nop,  ret && $countones(m_opc[2]) < 2);
    chk(tag, "wb_illegal", wb_ill, ret && $countones(m_opc[2]) > 2);
    chk("R8", "class_excl", $countones({wb_nop, wb_ill, |wb_ops}) <= 1, 1);
    if (counting) begin
      if (wb_ill) tally_ill++;
      if (wb_nop) tally_nop++;
      if (|wb_ops) begin
        tally_op++;
        seen |= wb_ops;
        chk("R1", "onehot", $countones(wb_ops), 1);
      end
    end
  endtask

  // drive one cycle: apply inputs, check after settle, model the edge
  task automatic cyc(string tag, logic v, logic [OW-1:0] o, logic st, logic fl);
    ivld = v; opc = o; stall = st; flush = fl;
    #1;
    check_outs(tag);
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < 3; i++) m_vld[i] = 1'b0;
    end else if (!st) begin
      m_vld[2] = m_vld[1]; m_opc[2] = m_opc[1];
      m_vld[1] = m_vld[0]; m_opc[1] = m_opc[0];
      m_vld[0] = v;        m_opc[0] = o;
    end
    @(negedge clk);
  endtask

  function automatic logic [OW-1:0] rand_opc();
    int lo, hi;
    logic [OW-1:0] r;
    if ($urandom % 2) begin
      lo = $urandom % OW;
      hi = (lo + 1 + ($urandom % (OW - 1))) % OW;
      r = '0; r[lo] = 1'b1; r[hi] = 1'b1;
      return r;
    end
    return OW'($urandom);
  endfunction

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h2a17));
    for (int i = 0; i < 3; i++) begin m_vld[i] = 1'b0; m_opc[i] = '0; end
    repeat (3) @(negedge clk);
    // R9: outputs quiet in reset
    check_outs("R9");
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R9");

    // R1 R2 R3: full sweep of all codes
    tally_op = 0; tally_nop = 0; tally_ill = 0; seen = '0;
    counting = 1'b1;
    for (int c = 0; c < 256; c++) cyc("R1", 1'b1, OW'(c), 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cyc("R4", 1'b0, '0, 1'b0, 1'b0);
    counting = 1'b0;
    chk("R1", "legal_count", tally_op, 28);
    chk("R1", "all_lines_seen", seen, {NO{1'b1}});
    chk("R2", "nop_count", tally_nop, 9);
    chk("R3", "illegal_count", tally_ill, 219);

    // R5: bubbles carry garbage opcodes but stay silent
    cyc("R5", 1'b0, 8'hff, 1'b0, 1'b0);
    cyc("R5", 1'b0, 8'h03, 1'b0, 1'b0);
    cyc("R5", 1'b1, 8'h00, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cyc("R5", 1'b0, 8'h81, 1'b0, 1'b0);

    // R6: illegal held at writeback under a long stall retires once
    cyc("R6", 1'b1, 8'h07, 1'b0, 1'b0);
    cyc("R6", 1'b1, 8'h0c, 1'b0, 1'b0);
    cyc("R6", 1'b1, 8'h10, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cyc("R6", 1'b1, 8'h30, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) cyc("R6", 1'b0, '0, 1'b0, 1'b0);

    // R7: flush during stall, input of that cycle dropped
    cyc("R7", 1'b1, 8'h18, 1'b0, 1'b0);
    cyc("R7", 1'b1, 8'hc0, 1'b0, 1'b0);
    cyc("R7", 1'b1, 8'h41, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) cyc("R7", 1'b0, '0, 1'b0, 1'b0);

    // R4: random traffic with stalls and flushes
    for (int i = 0; i < 3000; i++)
      cyc("R4", ($urandom % 4) != 0, rand_opc(),
          ($urandom % 7) == 0, ($urandom % 23) == 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule